// File: doc/BRIEF.md
# Start-up initialization sequencer

This block is the boot controller of a 16-channel coefficient-processing engine. After reset it runs once through a fixed series of phases, holding the interrupt enable low throughout. First it confirms that a ROM region and a RAM region are intact by summing their words and comparing each sum with a stored expected value. Next it fills the per-slot information tables for channel-order assignment, the channel address table and the default-set pointers. It then loads every per-channel coefficient table with its initial values and copies the shared receive/transmit filter coefficients from ROM into RAM. In the last step it raises the interrupt enable and sleep outputs together.

The block masters one synchronous ROM read port and one synchronous single-port RAM. Both return read data one cycle after the address is presented. If either checksum fails, the sequencer stops in an error state. It writes nothing to RAM in that case, and the interrupt enable stays low until the next reset. All sizes, base addresses, strides and initial coefficient values are parameters.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While reset is asserted, rom_en, ram_en, ram_we, irq_en, sleep, done and csum_err are all 0.
- R2: The ROM check sums ROM words 0 to ROM_CK_LEN-1 modulo 2^DW and compares the result with ROM word ROM_CK_LEN. On a mismatch, csum_err goes to 1 and stays there until reset, no RAM write ever occurs, and done and irq_en stay 0.
- R3: After the ROM check passes, and before any RAM write, the RAM check sums RAM words RAM_CK_BASE to RAM_CK_BASE+RAM_CK_LEN-1 modulo 2^DW and compares the result with RAM word RAM_CK_BASE+RAM_CK_LEN. A mismatch has the same effect as in R2.
- R4: For each slot n below CHANNELS, RAM word SLOT_BASE+2n is written with BUF_BASE+n*BUF_STRIDE (data buffer pointer), and word SLOT_BASE+2n+1 is written with COEF_BASE+n*COEF_LEN (coefficient pointer).
- R5: For each channel n, the channel address table word CAT_BASE+n is written with COEF_BASE+n*COEF_LEN.
- R6: For each k from 0 to NUM_DEF-1, word DEF_PTR_BASE+k is written with DEF_BASE+k*COEF_LEN.
- R7: For every channel n and every entry j below COEF_LEN, RAM word COEF_BASE+n*COEF_LEN+j is written with bits [j*DW +: DW] of COEF_INIT.
- R8: For each i below FILT_LEN, RAM word FILT_RAM_BASE+i is written with ROM word FILT_ROM_BASE+i.
- R9: irq_en stays 0 during the whole sequence. When the sequence completes, irq_en, sleep and done rise in the same cycle and stay at 1 until reset, and no further ROM or RAM access takes place.
- R10: A successful run makes exactly 3*CHANNELS + NUM_DEF + CHANNELS*COEF_LEN + FILT_LEN RAM writes. Every RAM word outside the regions of R4 to R8 keeps its prior value.
- R11: The checksums wrap modulo 2^DW, so regions whose true sum exceeds the word width still pass when the stored value equals the truncated sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_en | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW | ROM read address |
| rom_rdata | input | DW | ROM data, one cycle after rom_en |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable (with ram_en) |
| ram_addr | output | RAM_AW | RAM address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after a read |
| irq_en | output | 1 | Interrupt enable, raised only at the end |
| sleep | output | 1 | Engine has entered sleep |
| done | output | 1 | Sequence completed successfully |
| csum_err | output | 1 | A checksum mismatch halted the sequence |

## Verification
The corner cases are a stored checksum that is off by one in the ROM and in the RAM region, and regions of all-ones words whose sum wraps past the word width. A design that skipped the comparison, or compared too early in the read pipeline, would either finish despite a bad checksum or halt on a good one. A design that did not truncate the sum would halt on the wrapping case. Each run compares the whole RAM image with a model built by the bench. An off-by-one in the pointer or stride arithmetic, a filter copy shifted by one cycle of ROM latency, or a stray write to a neighbouring region would each show up as a mismatched word or a wrong write count.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ROMCK,
      ST_ROMFIN,
      ST_RAMCK,
      ST_RAMFIN,
      ST_SLOT,
      ST_CAT,
      ST_DEF,
      ST_COEF,
      ST_FILT,
      ST_FILTFIN,
      ST_SLEEP,
      ST_HALT
   } boot_state_e;

   typedef enum logic [1:0] {
      WR_SLOT,
      WR_CAT,
      WR_DEF,
      WR_COEF
   } wr_kind_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/boot_csum_unit.sv
// Running modular sum over a read stream; the final word of the stream is
// the stored expectation and is compared combinationally when it arrives.
module boot_csum_unit #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          issue_last,
   input  logic [DW-1:0] rdata,
   output logic          fin,
   output logic          ok
);

   logic          vld_q;
   logic          last_q;
   logic [DW-1:0] sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         last_q <= 1'b0;
         sum_q  <= '0;
      end else begin
         vld_q  <= issue;
         last_q <= issue & issue_last;
         if (vld_q) begin
            if (last_q) sum_q <= '0;
            else        sum_q <= sum_q + rdata;
         end
      end
   end

   assign fin = vld_q & last_q;
   assign ok  = (sum_q == rdata);

endmodule

// File: rtl/boot_wr_gen.sv
// Address and data for the table-fill phases, indexed by a step counter.
module boot_wr_gen
   import boot_seq_pkg::*;
#(
   parameter int DW           = 16,
   parameter int RAM_AW       = 9,
   parameter int IW           = 8,
   parameter int SLOT_BASE    = 0,
   parameter int BUF_BASE     = 64,
   parameter int BUF_STRIDE   = 8,
   parameter int CAT_BASE     = 256,
   parameter int DEF_PTR_BASE = 272,
   parameter int COEF_BASE    = 288,
   parameter int COEF_LEN     = 8,
   parameter int DEF_BASE     = 416,
   parameter logic [COEF_LEN*DW-1:0] COEF_INIT = '0
) (
   input  wr_kind_e          kind,
   input  logic [IW-1:0]     idx,
   output logic [RAM_AW-1:0] addr,
   output logic [DW-1:0]     data
);

   localparam int CLW = $clog2(COEF_LEN);

   logic [DW-1:0] init_w [COEF_LEN];
   logic [IW-1:0] slot_n;

   for (genvar g = 0; g < COEF_LEN; g++) begin : g_init
      assign init_w[g] = COEF_INIT[g*DW +: DW];
   end

   assign slot_n = idx >> 1;

   always_comb begin
      unique case (kind)
         WR_SLOT: begin
            addr = RAM_AW'(SLOT_BASE) + RAM_AW'(idx);
            data = idx[0] ? DW'(COEF_BASE) + DW'(slot_n) * DW'(COEF_LEN)
                          : DW'(BUF_BASE)  + DW'(slot_n) * DW'(BUF_STRIDE);
         end
         WR_CAT: begin
            addr = RAM_AW'(CAT_BASE) + RAM_AW'(idx);
            data = DW'(COEF_BASE) + DW'(idx) * DW'(COEF_LEN);
         end
         WR_DEF: begin
            addr = RAM_AW'(DEF_PTR_BASE) + RAM_AW'(idx);
            data = DW'(DEF_BASE) + DW'(idx) * DW'(COEF_LEN);
         end
         default: begin
            addr = RAM_AW'(COEF_BASE) + RAM_AW'(idx);
            data = init_w[idx[CLW-1:0]];
         end
      endcase
   end

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
   import boot_seq_pkg::*;
#(
   parameter int DW            = 16,
   parameter int ROM_AW        = 6,
   parameter int RAM_AW        = 9,
   parameter int CHANNELS      = 16,
   parameter int NUM_DEF       = 3,
   parameter int ROM_CK_LEN    = 31,
   parameter int RAM_CK_BASE   = 480,
   parameter int RAM_CK_LEN    = 15,
   parameter int SLOT_BASE     = 0,
   parameter int BUF_BASE      = 64,
   parameter int BUF_STRIDE    = 8,
   parameter int CAT_BASE      = 256,
   parameter int DEF_PTR_BASE  = 272,
   parameter int COEF_BASE     = 288,
   parameter int COEF_LEN      = 8,
   parameter int DEF_BASE      = 416,
   parameter int FILT_ROM_BASE = 32,
   parameter int FILT_RAM_BASE = 448,
   parameter int FILT_LEN      = 16,
   parameter logic [COEF_LEN*DW-1:0] COEF_INIT =
      128'h7F00_0C31_F5A2_0400_1234_8001_00FF_A5A5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rom_en,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [DW-1:0]     rom_rdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DW-1:0]     ram_wdata,
   input  logic [DW-1:0]     ram_rdata,
   output logic              irq_en,
   output logic              sleep,
   output logic              done,
   output logic              csum_err
);

   localparam int MAXCNT = max2(max2(max2(ROM_CK_LEN + 1, RAM_CK_LEN + 1),
                                     max2(2 * CHANNELS, CHANNELS * COEF_LEN)),
                                max2(FILT_LEN, NUM_DEF));
   localparam int IW = $clog2(MAXCNT + 1);

   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("boot_seq_ctrl: DW must lie in 8..32");
   end
   if (COEF_LEN < 2 || (COEF_LEN & (COEF_LEN - 1)) != 0) begin : g_bad_coef
      $error("boot_seq_ctrl: COEF_LEN must be a power of two, at least 2");
   end
   if (ROM_CK_LEN + 1 > (1 << ROM_AW) || FILT_ROM_BASE + FILT_LEN > (1 << ROM_AW)) begin : g_bad_rom
      $error("boot_seq_ctrl: ROM regions exceed the ROM address space");
   end
   if (RAM_CK_BASE + RAM_CK_LEN + 1 > (1 << RAM_AW) ||
       FILT_RAM_BASE + FILT_LEN > (1 << RAM_AW)) begin : g_bad_ram
      $error("boot_seq_ctrl: RAM regions exceed the RAM address space");
   end

   boot_state_e   state, state_n;
   logic [IW-1:0] idx, idx_n;
   logic          cp_vld;
   logic [IW-1:0] cp_idx;

   logic          ck_issue, ck_last, ck_fin, ck_ok;
   logic [DW-1:0] ck_data;
   wr_kind_e      wr_kind;
   logic          wr_phase;
   logic [RAM_AW-1:0] gen_addr;
   logic [DW-1:0]     gen_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         cp_vld <= 1'b0;
         cp_idx <= '0;
      end else begin
         state  <= state_n;
         idx    <= idx_n;
         cp_vld <= (state == ST_FILT);
         cp_idx <= idx;
      end
   end

   always_comb begin
      state_n = state;
      idx_n   = idx + 1'b1;
      unique case (state)
         ST_IDLE: begin
            state_n = ST_ROMCK;
            idx_n   = '0;
         end
         ST_ROMCK:  if (idx == IW'(ROM_CK_LEN)) begin state_n = ST_ROMFIN; idx_n = '0; end
         ST_ROMFIN: begin
            idx_n = '0;
            if (ck_fin) state_n = ck_ok ? ST_RAMCK : ST_HALT;
         end
         ST_RAMCK:  if (idx == IW'(RAM_CK_LEN)) begin state_n = ST_RAMFIN; idx_n = '0; end
         ST_RAMFIN: begin
            idx_n = '0;
            if (ck_fin) state_n = ck_ok ? ST_SLOT : ST_HALT;
         end
         ST_SLOT: if (idx == IW'(2 * CHANNELS - 1))        begin state_n = ST_CAT;  idx_n = '0; end
         ST_CAT:  if (idx == IW'(CHANNELS - 1))            begin state_n = ST_DEF;  idx_n = '0; end
         ST_DEF:  if (idx == IW'(NUM_DEF - 1))             begin state_n = ST_COEF; idx_n = '0; end
         ST_COEF: if (idx == IW'(CHANNELS * COEF_LEN - 1)) begin state_n = ST_FILT; idx_n = '0; end
         ST_FILT: if (idx == IW'(FILT_LEN - 1))            begin state_n = ST_FILTFIN; idx_n = '0; end
         ST_FILTFIN: begin
            state_n = ST_SLEEP;
            idx_n   = '0;
         end
         default: idx_n = idx;
      endcase
   end

   // checksum stream
   assign ck_issue = (state == ST_ROMCK) || (state == ST_RAMCK);
   assign ck_last  = (state == ST_ROMCK) ? (idx == IW'(ROM_CK_LEN)) : (idx == IW'(RAM_CK_LEN));
   assign ck_data  = ((state == ST_ROMCK) || (state == ST_ROMFIN)) ? rom_rdata : ram_rdata;

   boot_csum_unit #(.DW(DW)) u_csum (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (ck_issue),
      .issue_last(ck_last),
      .rdata     (ck_data),
      .fin       (ck_fin),
      .ok        (ck_ok)
   );

   // table fill
   always_comb begin
      unique case (state)
         ST_SLOT: wr_kind = WR_SLOT;
         ST_CAT:  wr_kind = WR_CAT;
         ST_DEF:  wr_kind = WR_DEF;
         default: wr_kind = WR_COEF;
      endcase
   end
   assign wr_phase = (state == ST_SLOT) || (state == ST_CAT) ||
                     (state == ST_DEF)  || (state == ST_COEF);

   boot_wr_gen #(
      .DW(DW), .RAM_AW(RAM_AW), .IW(IW),
      .SLOT_BASE(SLOT_BASE), .BUF_BASE(BUF_BASE), .BUF_STRIDE(BUF_STRIDE),
      .CAT_BASE(CAT_BASE), .DEF_PTR_BASE(DEF_PTR_BASE), .COEF_BASE(COEF_BASE),
      .COEF_LEN(COEF_LEN), .DEF_BASE(DEF_BASE), .COEF_INIT(COEF_INIT)
   ) u_wr_gen (
      .kind(wr_kind),
      .idx (idx),
      .addr(gen_addr),
      .data(gen_data)
   );

   // memory ports
   always_comb begin
      rom_en   = (state == ST_ROMCK) || (state == ST_FILT);
      rom_addr = (state == ST_FILT) ? ROM_AW'(FILT_ROM_BASE) + ROM_AW'(idx) : ROM_AW'(idx);

      ram_en    = (state == ST_RAMCK) || wr_phase || cp_vld;
      ram_we    = wr_phase || cp_vld;
      ram_addr  = RAM_AW'(RAM_CK_BASE) + RAM_AW'(idx);
      ram_wdata = gen_data;
      if (wr_phase) begin
         ram_addr = gen_addr;
      end else if (cp_vld) begin
         ram_addr  = RAM_AW'(FILT_RAM_BASE) + RAM_AW'(cp_idx);
         ram_wdata = rom_rdata;
      end
   end

   assign done     = (state == ST_SLEEP);
   assign sleep    = (state == ST_SLEEP);
   assign irq_en   = (state == ST_SLEEP);
   assign csum_err = (state == ST_HALT);

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic rom_en,
   input logic ram_en,
   input logic ram_we,
   input logic irq_en,
   input logic sleep,
   input logic done,
   input logic csum_err
);

   AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en |-> done && sleep);                                   // R9
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && irq_en);                                    // R9
   AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rom_en && !ram_en);                               // R9
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      csum_err |=> csum_err && !ram_we);                           // R2
   AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      csum_err |-> !done && !irq_en);                              // R3
   AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_en && !csum_err);                             // R10

endmodule

bind boot_seq_ctrl boot_seq_chk u_boot_seq_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rom_en  (rom_en),
   .ram_en  (ram_en),
   .ram_we  (ram_we),
   .irq_en  (irq_en),
   .sleep   (sleep),
   .done    (done),
   .csum_err(csum_err)
);

// File: tb/boot_seq_ctrl_test.sv
module boot_seq_ctrl_test;

   localparam int CLK_PERIOD    = 10;
   localparam int DW            = 16;
   localparam int ROM_AW        = 6;
   localparam int RAM_AW        = 9;
   localparam int CHANNELS      = 16;
   localparam int NUM_DEF       = 3;
   localparam int ROM_CK_LEN    = 31;
   localparam int RAM_CK_BASE   = 480;
   localparam int RAM_CK_LEN    = 15;
   localparam int SLOT_BASE     = 0;
   localparam int BUF_BASE      = 64;
   localparam int BUF_STRIDE    = 8;
   localparam int CAT_BASE      = 256;
   localparam int DEF_PTR_BASE  = 272;
   localparam int COEF_BASE     = 288;
   localparam int COEF_LEN      = 8;
   localparam int DEF_BASE      = 416;
   localparam int FILT_ROM_BASE = 32;
   localparam int FILT_RAM_BASE = 448;
   localparam int FILT_LEN      = 16;
   localparam logic [COEF_LEN*DW-1:0] COEF_INIT = 128'h0102_FFFF_8000_0001_3C3C_00AA_5500_0F0F;
   localparam int ROM_WORDS = 1 << ROM_AW;
   localparam int RAM_WORDS = 1 << RAM_AW;
   localparam int EXP_WRITES = 3 * CHANNELS + NUM_DEF + CHANNELS * COEF_LEN + FILT_LEN;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rom_en, ram_en, ram_we, irq_en, sleep, done, csum_err;
   logic [ROM_AW-1:0] rom_addr;
   logic [RAM_AW-1:0] ram_addr;
   logic [DW-1:0]     rom_q, ram_q, ram_wdata;

   logic [DW-1:0] rom_mem  [ROM_WORDS];
   logic [DW-1:0] ram_mem  [RAM_WORDS];
   logic [DW-1:0] ram_init [RAM_WORDS];
   logic              ld_en = 1'b0;
   logic [RAM_AW-1:0] ld_addr = '0;
   logic [DW-1:0]     ld_data = '0;
   int                wr_cnt;
   int                checks = 0;
   int                errors = 0;
   int                cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   boot_seq_ctrl #(
      .DW(DW), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .CHANNELS(CHANNELS), .NUM_DEF(NUM_DEF),
      .ROM_CK_LEN(ROM_CK_LEN), .RAM_CK_BASE(RAM_CK_BASE), .RAM_CK_LEN(RAM_CK_LEN),
      .SLOT_BASE(SLOT_BASE), .BUF_BASE(BUF_BASE), .BUF_STRIDE(BUF_STRIDE),
      .CAT_BASE(CAT_BASE), .DEF_PTR_BASE(DEF_PTR_BASE), .COEF_BASE(COEF_BASE),
      .COEF_LEN(COEF_LEN), .DEF_BASE(DEF_BASE), .FILT_ROM_BASE(FILT_ROM_BASE),
      .FILT_RAM_BASE(FILT_RAM_BASE), .FILT_LEN(FILT_LEN), .COEF_INIT(COEF_INIT)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_q),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_q),
      .irq_en(irq_en), .sleep(sleep), .done(done), .csum_err(csum_err)
   );

   // synchronous memory models
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rom_en) rom_q <= rom_mem[rom_addr];
      if (ld_en) ram_mem[ld_addr] <= ld_data;
      else if (ram_en) begin
         if (ram_we) ram_mem[ram_addr] <= ram_wdata;
         ram_q <= ram_mem[ram_addr];
      end
      if (!rst_n) wr_cnt <= 0;
      else if (ram_en && ram_we) wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] coef_word(input int j);
      return COEF_INIT[j*DW +: DW];
   endfunction

   function automatic bit written(input int a);
      return (a >= SLOT_BASE && a < SLOT_BASE + 2 * CHANNELS) ||
             (a >= CAT_BASE && a < CAT_BASE + CHANNELS) ||
             (a >= DEF_PTR_BASE && a < DEF_PTR_BASE + NUM_DEF) ||
             (a >= COEF_BASE && a < COEF_BASE + CHANNELS * COEF_LEN) ||
             (a >= FILT_RAM_BASE && a < FILT_RAM_BASE + FILT_LEN);
   endfunction

   // kind: 0 random good, 1 all-ones wrap, 2 bad ROM sum, 3 bad RAM sum
   task automatic run_case(input int kind, input bit check_reset);
      logic [31:0] sum;
      int          bad;
      int          waited;
      rst_n = 1'b0;
      sum = 0;
      for (int a = 0; a < ROM_WORDS; a++) begin
         rom_mem[a] = (kind == 1) ? '1 : DW'($urandom);
         if (a < ROM_CK_LEN) sum = sum + 32'(rom_mem[a]);
      end
      rom_mem[ROM_CK_LEN] = DW'(sum) + ((kind == 2) ? DW'(1) : DW'(0));
      sum = 0;
      for (int a = 0; a < RAM_WORDS; a++) begin
         @(negedge clk);
         ld_en   = 1'b1;
         ld_addr = RAM_AW'(a);
         if (a == RAM_CK_BASE + RAM_CK_LEN)
            ld_data = DW'(sum) + ((kind == 3) ? DW'(1) : DW'(0));
         else
            ld_data = (kind == 1 && a >= RAM_CK_BASE) ? '1 : DW'($urandom);
         if (a >= RAM_CK_BASE && a < RAM_CK_BASE + RAM_CK_LEN) sum = sum + 32'(ld_data);
         ram_init[a] = ld_data;
      end
      @(negedge clk);
      ld_en = 1'b0;
      @(negedge clk);
      if (check_reset) begin
         chk("R1", {25'd0, rom_en, ram_en, ram_we, irq_en, sleep, done, csum_err}, 0, "outputs in reset");
      end
      rst_n = 1'b1;
      waited = 0;
      bad = 0;
      while (!done && !csum_err && waited < 3000) begin
         @(negedge clk);
         if (irq_en && !done) bad++;
         waited++;
      end
      chk("R9", bad, 0, "irq_en early");
      repeat (4) @(negedge clk);

      if (kind >= 2) begin
         chk(kind == 2 ? "R2" : "R3", {29'd0, csum_err, done, irq_en}, 4, "err/done/irq");
         chk(kind == 2 ? "R2" : "R3", wr_cnt, 0, "writes after bad sum");
         bad = 0;
         for (int a = 0; a < RAM_WORDS; a++) if (ram_mem[a] != ram_init[a]) bad++;
         chk(kind == 2 ? "R2" : "R3", bad, 0, "ram words changed");
         return;
      end

      chk(kind == 1 ? "R11" : "R9", {28'd0, done, sleep, irq_en, csum_err}, 14, "end status");
      chk("R9", {30'd0, rom_en, ram_en}, 0, "access while asleep");
      chk("R10", wr_cnt, EXP_WRITES, "write count");
      bad = 0;
      for (int n = 0; n < CHANNELS; n++) begin
         if (ram_mem[SLOT_BASE + 2*n]     != DW'(BUF_BASE + n * BUF_STRIDE)) bad++;
         if (ram_mem[SLOT_BASE + 2*n + 1] != DW'(COEF_BASE + n * COEF_LEN)) bad++;
      end
      chk("R4", bad, 0, "slot table words wrong");
      bad = 0;
      for (int n = 0; n < CHANNELS; n++)
         if (ram_mem[CAT_BASE + n] != DW'(COEF_BASE + n * COEF_LEN)) bad++;
      chk("R5", bad, 0, "channel address words wrong");
      bad = 0;
      for (int k = 0; k < NUM_DEF; k++)
         if (ram_mem[DEF_PTR_BASE + k] != DW'(DEF_BASE + k * COEF_LEN)) bad++;
      chk("R6", bad, 0, "default pointer words wrong");
      bad = 0;
      for (int n = 0; n < CHANNELS; n++)
         for (int j = 0; j < COEF_LEN; j++)
            if (ram_mem[COEF_BASE + n * COEF_LEN + j] != coef_word(j)) bad++;
      chk("R7", bad, 0, "coefficient words wrong");
      bad = 0;
      for (int i = 0; i < FILT_LEN; i++)
         if (ram_mem[FILT_RAM_BASE + i] != rom_mem[FILT_ROM_BASE + i]) bad++;
      chk("R8", bad, 0, "filter words wrong");
      bad = 0;
      for (int a = 0; a < RAM_WORDS; a++)
         if (!written(a) && ram_mem[a] != ram_init[a]) bad++;
      chk("R10", bad, 0, "untouched words changed");
   endtask

   initial begin
      void'($urandom(32'd20240611));
      run_case(0, 1'b1);
      run_case(1, 1'b0);
      run_case(2, 1'b1);
      run_case(0, 1'b0);
      run_case(3, 1'b0);
      run_case(0, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule